// File: doc/BRIEF.md
# Coprocessor Execution Control Sequencer

This block is the control state machine between a host processor and a tightly coupled reconfigurable coprocessor. The host issues one command per cycle. The commands load a configuration, write the coprocessor's initial registers, start a run, halt it, resume it and read results back. The sequencer decides whether each command is legal in the present state. A legal command is carried out. An illegal command is refused and reported with a one-cycle error pulse.

The sequencer has four states: idle, loading, running and halted. The array fabric is modelled as a counter. A load command sets a run length. A run ends after that many active cycles have been counted, and halted cycles are not counted. At the end of a run the fabric model adds the effective run length to every register. A result-valid flag then stays set until the host reads a register.

Top module: `cp_exec_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `busy`, `err`, `done`, `res_valid` and `rd_valid` are all 0. No configuration is loaded and every register reads 0.
- R2: A load (op 1) is accepted only in idle. It latches the run length L from `cmd_data[CW-1:0]` and enters loading (state 1). Loading lasts exactly LOAD_CYC cycles, after which the state returns to idle with a configuration marked as loaded.
- R3: A start (op 3) issued in idle enters running (state 2) on the next cycle if a configuration is loaded. If no configuration has been loaded since reset, the start is ignored: the state stays idle and no error is raised.
- R4: A run spans max(L,1) running cycles in total. After the last one the state returns to idle, `done` pulses for one cycle, and every register has max(L,1) added to it.
- R5: A halt (op 4) issued in running, other than in the final running cycle, enters halted (state 3) on the next cycle. A resume (op 5) issued in halted returns to running. The run continues its count without a reload.
- R6: A register write (op 2, `regs[cmd_addr] = cmd_data`) and a register read (op 6) are legal in idle and in halted. The read returns `regs[cmd_addr]` on `rd_data`, with `rd_valid` high, on the cycle after the command.
- R7: The following commands are illegal: a load or start outside idle, a register access in loading or running, a halt outside running or in the final running cycle, and a resume outside halted. An illegal command is not performed. It raises `err` for exactly the next cycle, and a state that is not ending a run or a load keeps its value.
- R8: `res_valid` is set together with `done` and stays set until a legal register read. That read clears it.
- R9: `busy` is high exactly while the state is loading or running.
- R10: Op 0 and op 7 have no effect and never raise `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (0 none, 1 load, 2 write, 3 start, 4 halt, 5 resume, 6 read, 7 none) |
| cmd_addr | input | AW | Register index for a write or read |
| cmd_data | input | DW | Write data; for a load, bits CW-1:0 give the run length |
| state_o | output | 2 | 0 idle, 1 loading, 2 running, 3 halted |
| busy | output | 1 | High in loading and in running |
| err | output | 1 | One-cycle pulse after an illegal command |
| done | output | 1 | One-cycle pulse when a run completes |
| res_valid | output | 1 | Results are ready and have not yet been read |
| rd_valid | output | 1 | `rd_data` holds the answer to a read |
| rd_data | output | DW | Data returned by a read |

## Verification
Every cycle, the bound checker verifies four things:
- the lockout of loads outside idle;
- that no run begins without a start;
- that halted can only move on to running;
- that `done`, `err`, `res_valid` and `rd_valid` respond as required to the command of the previous cycle.

Three properties depend on history that spans many cycles, so only the bench scenarios can show them: that the running cycles add up to the programmed length across any number of halt and resume pairs, that the register contents are correct after a run, and that loading lasts exactly LOAD_CYC cycles. The bench compares every output against a reference model on every cycle. It drives random command traffic together with directed sequences: a start before any load, accesses during loading, a halt followed by a read and then a resume, and a read that clears the results.

// File: rtl/cp_exec_seq.sv
module cp_exec_seq #(
  parameter int DW       = 32,
  parameter int NREG     = 4,
  parameter int LOAD_CYC = 5,
  parameter int CW       = 16,
  localparam int AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic [1:0]    state_o,
  output logic          busy,
  output logic          err,
  output logic          done,
  output logic          res_valid,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [1:0] S_IDLE = 2'd0, S_LOAD = 2'd1, S_RUN = 2'd2, S_HALT = 2'd3;
  localparam logic [2:0] OP_LOAD = 3'd1, OP_WR = 3'd2, OP_START = 3'd3,
                         OP_HALT = 3'd4, OP_RES = 3'd5, OP_RD = 3'd6;

  logic [1:0]    st;
  logic [CW-1:0] cnt, len;
  logic          cfg_ok;
  logic [DW-1:0] regs [NREG];

  wire [CW:0]    cnt_nx   = {1'b0, cnt} + 1'b1;
  wire [CW-1:0]  run_eff  = (len == '0) ? {{(CW-1){1'b0}}, 1'b1} : len;
  wire           last_run = (st == S_RUN) && (cnt_nx >= {1'b0, len});
  wire           last_ld  = (st == S_LOAD) && (cnt == CW'(LOAD_CYC - 1));
  wire           acc_ok   = (st == S_IDLE) || (st == S_HALT);

  wire do_load  = cmd_valid && cmd_op == OP_LOAD  && st == S_IDLE;
  wire do_start = cmd_valid && cmd_op == OP_START && st == S_IDLE;
  wire do_halt  = cmd_valid && cmd_op == OP_HALT  && st == S_RUN && !last_run;
  wire do_res   = cmd_valid && cmd_op == OP_RES   && st == S_HALT;
  wire do_wr    = cmd_valid && cmd_op == OP_WR    && acc_ok;
  wire do_rd    = cmd_valid && cmd_op == OP_RD    && acc_ok;

  wire known    = cmd_op != 3'd0 && cmd_op != 3'd7;
  wire refused  = cmd_valid && known &&
                  !(do_load || do_start || do_halt || do_res || do_wr || do_rd);

  assign state_o = st;
  assign busy    = (st == S_LOAD) || (st == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      len       <= '0;
      cfg_ok    <= 1'b0;
      err       <= 1'b0;
      done      <= 1'b0;
      res_valid <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      err      <= refused;
      done     <= 1'b0;
      rd_valid <= do_rd;
      if (do_rd) begin
        rd_data   <= regs[cmd_addr];
        res_valid <= 1'b0;
      end
      if (do_wr) regs[cmd_addr] <= cmd_data;
      unique case (st)
        S_IDLE: begin
          if (do_load) begin
            st     <= S_LOAD;
            cnt    <= '0;
            len    <= cmd_data[CW-1:0];
            cfg_ok <= 1'b0;
          end else if (do_start && cfg_ok) begin
            st  <= S_RUN;
            cnt <= '0;
          end
        end
        S_LOAD: begin
          cnt <= cnt_nx[CW-1:0];
          if (last_ld) begin
            st     <= S_IDLE;
            cfg_ok <= 1'b1;
          end
        end
        S_RUN: begin
          cnt <= cnt_nx[CW-1:0];
          if (last_run) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            res_valid <= 1'b1;
            for (int i = 0; i < NREG; i++)
              regs[i] <= regs[i] + DW'(run_eff);
          end else if (do_halt) begin
            st <= S_HALT;
          end
        end
        S_HALT: if (do_res) st <= S_RUN;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cp_exec_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic [1:0] state_o,
  input logic       err,
  input logic       done,
  input logic       res_valid,
  input logic       rd_valid
);
  // R7
  load_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && state_o != 2'd0) |=> err);
  // R7
  halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && state_o == 2'd3) |=> state_o == 2'd3);
  // R3
  no_stray_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !(cmd_valid && cmd_op == 3'd3)) |=> state_o != 2'd2);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_o == 2'd0 && res_valid));
  // R5
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd3 |=> (state_o == 2'd3 || state_o == 2'd2));
  // R6
  read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6 && (state_o == 2'd0 || state_o == 2'd3)) |=> (rd_valid && !res_valid));
  // R10
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd7)) |=> !err);
endmodule

bind cp_exec_seq cp_exec_seq_chk u_chk (.*);

// File: tb/sim_cp_exec_seq.sv
`timescale 1ns/1ps
module sim_cp_exec_seq;
  localparam int DW = 32, NREG = 4, LOAD_CYC = 5, CW = 16, AW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [1:0] state_o;
  logic busy, err, done, res_valid, rd_valid;
  logic [DW-1:0] rd_data;

  cp_exec_seq #(.DW(DW), .NREG(NREG), .LOAD_CYC(LOAD_CYC), .CW(CW)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  int m_st, m_cnt, m_len;
  bit m_cfg, e_err, e_done, e_res, e_rdv;
  logic [DW-1:0] m_regs [NREG];
  logic [DW-1:0] e_rdd;

  function automatic bit legal_f(int op, int st, bit lastrun);
    case (op)
      1, 3:    return st == 0;
      2, 6:    return st == 0 || st == 3;
      4:       return st == 2 && !lastrun;
      5:       return st == 3;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int eff_len(int l);
    return (l == 0) ? 1 : l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_len = 0; m_cfg = 0;
      e_err = 0; e_done = 0; e_res = 0; e_rdv = 0; e_rdd = '0;
      for (int i = 0; i < NREG; i++) m_regs[i] = '0;
    end else begin
      bit lr, ok;
      int op;
      op = cmd_op;
      lr = (m_st == 2) && (m_cnt + 1 >= m_len);
      ok = legal_f(op, m_st, lr);
      e_err = cmd_valid && !ok;
      e_done = 0;
      e_rdv = cmd_valid && op == 6 && ok;
      if (e_rdv) begin e_rdd = m_regs[cmd_addr]; e_res = 0; end
      if (cmd_valid && op == 2 && ok) m_regs[cmd_addr] = cmd_data;
      case (m_st)
        0: if (cmd_valid && op == 1) begin
             m_st = 1; m_cnt = 0; m_len = int'(cmd_data[CW-1:0]); m_cfg = 0;
           end else if (cmd_valid && op == 3 && m_cfg) begin
             m_st = 2; m_cnt = 0;
           end
        1: begin
             if (m_cnt == LOAD_CYC - 1) begin m_st = 0; m_cfg = 1; end
             m_cnt++;
           end
        2: begin
             if (lr) begin
               m_st = 0; e_done = 1; e_res = 1;
               for (int i = 0; i < NREG; i++) m_regs[i] += DW'(eff_len(m_len));
             end else if (cmd_valid && op == 4) m_st = 3;
             m_cnt++;
           end
        default: if (cmd_valid && op == 5) m_st = 2;
      endcase
    end
  end

  int run_cycles;
  always @(negedge clk) begin
    if (rst_n) begin
      if (state_o == 2'd2) run_cycles++;
      chk(state_o == 2'(m_st), "R7 state", state_o, m_st);
      chk(busy == (m_st == 1 || m_st == 2), "R9 busy", busy, (m_st == 1 || m_st == 2));
      chk(err == e_err, "R7 err", err, e_err);
      chk(done == e_done, "R4 done", done, e_done);
      chk(res_valid == e_res, "R8 res_valid", res_valid, e_res);
      chk(rd_valid == e_rdv, "R6 rd_valid", rd_valid, e_rdv);
      if (e_rdv) chk(rd_data == e_rdd, "R6 rd_data", rd_data, e_rdd);
    end
  end

  task automatic issue(input bit v, input int op, input int a, input int d);
    @(negedge clk); #1;
    cmd_valid = v; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_data = DW'(d);
  endtask

  task automatic quiet();
    issue(0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(state_o == 0 && !busy && !res_valid && !err && !done, "R1 reset", state_o, 0);
    issue(1, 6, 2, 0); quiet();
    chk(rd_valid && rd_data == 0, "R1 regs clear", rd_data, 0);
    // R3 start without configuration is ignored
    issue(1, 3, 0, 0); quiet();
    chk(state_o == 0 && !err, "R3 start ignored", state_o, 0);
    // R10 op 7 does nothing
    issue(1, 7, 1, 99); quiet();
    chk(!err && state_o == 0, "R10 op7", err, 0);
    // R2 load, length 3
    issue(1, 1, 0, 3); quiet();
    chk(state_o == 1 && busy, "R2 loading", state_o, 1);
    issue(1, 2, 0, 55); quiet();
    chk(err == 1, "R7 write in loading", err, 1);
    begin
      int lc = 2;
      while (state_o == 1) begin quiet(); lc++; end
      chk(lc == LOAD_CYC, "R2 load length", lc, LOAD_CYC);
    end
    for (int i = 0; i < NREG; i++) issue(1, 2, i, 10 * i);
    run_cycles = 0;
    issue(1, 3, 0, 0);
    issue(1, 4, 0, 0);
    quiet();
    chk(state_o == 3 && !busy, "R5 halted", state_o, 3);
    issue(1, 6, 1, 0); quiet();
    chk(rd_valid && rd_data == 10, "R6 read in halt", rd_data, 10);
    issue(1, 5, 0, 0); quiet();
    chk(state_o == 2, "R5 resumed", state_o, 2);
    repeat (4) quiet();
    chk(run_cycles == 3, "R4 total run cycles", run_cycles, 3);
    chk(res_valid, "R8 res set", res_valid, 1);
    issue(1, 6, 2, 0); quiet();
    chk(rd_data == 23 && !res_valid, "R4 result reg2", rd_data, 23);
    // random phase
    for (int n = 0; n < 6000; n++) begin
      int op, dd;
      op = $urandom_range(0, 7);
      if (op == 1 && $urandom_range(0, 3) != 0) op = 6;
      dd = $urandom_range(0, 12);
      issue($urandom_range(0, 3) != 0, op, $urandom_range(0, NREG - 1),
            (op == 1) ? dd : $urandom);
    end
    quiet(); quiet();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule